// File: doc/BRIEF.md
# Cartridge Bank Address Translator

This block turns the processor and picture-unit bus addresses of a cartridge into physical memory addresses. It reads four already-loaded 5-bit register values: a mode word, two pattern-bank selectors and a program-bank selector. It is purely combinational. A program address appears for every processor access in the upper 32 KB. A pattern address appears for every picture-unit access in the lower 8 KB. The block also reports the nametable arrangement, picks the nametable page for the current picture-unit address, and enables the work RAM.

The mode word sets three things. It chooses between one 32 KB program window and two 16 KB windows. In 16 KB mode it chooses which window switches, and the other window is pinned to the first bank or the last bank. It also chooses between one 8 KB pattern window and two 4 KB ones. The program bank count is a parameter, and any bank index larger than the count wraps.

Top module: `bank_xlate`

## Requirements
- R1: `mirrorMode` equals mode bits 1:0, coded 0 = single page low, 1 = single page high, 2 = vertical arrangement, 3 = horizontal arrangement.
- R2: When mode bit 3 is 0, program bank = ((prg bits 3:1) × 2 + cpuAddr bit 14) mod PRG_BANKS. Program bit 0 is ignored.
- R3: When mode bits 3 and 2 are both 1, addresses $8000–$BFFF use the selected bank and $C000–$FFFF use bank PRG_BANKS−1.
- R4: When mode bit 3 is 1 and bit 2 is 0, addresses $8000–$BFFF use bank 0 and $C000–$FFFF use the selected bank.
- R5: In every mode, `prgRomAddr` = bank × 16384 + (cpuAddr mod 16384). The selected bank is (prg bits 3:0) mod PRG_BANKS.
- R6: `prgRomSel` is 1 exactly when cpuAddr ≥ $8000.
- R7: When mode bit 4 is 0, `chrAddr` = (chrLo bits 4:1) × 8192 + ppuAddr bits 12:0. `chrHiReg` has no effect.
- R8: When mode bit 4 is 1, `chrAddr` = bank × 4096 + ppuAddr bits 11:0. The bank is `chrLoReg` when ppuAddr bit 12 is 0 and `chrHiReg` when it is 1.
- R9: `chrSel` is 1 exactly when ppuAddr < $2000.
- R10: `wramCe` is 1 exactly when cpuAddr is in $6000–$7FFF and prg bit 4 is 0. Prg bit 4 has no effect on the program address.
- R11: `ntPage` is 0 in mode 0 and 1 in mode 1. In mode 2 it is ppuAddr bit 10, and in mode 3 it is ppuAddr bit 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpuAddr | input | 16 | Processor bus address |
| ppuAddr | input | 14 | Picture-unit bus address |
| ctrlReg | input | 5 | Mode word: arrangement, program layout, pattern size |
| chrLoReg | input | 5 | Pattern bank selector for the lower (or whole) window |
| chrHiReg | input | 5 | Pattern bank selector for the upper 4 KB window |
| prgReg | input | 5 | Program bank in bits 3:0, work-RAM disable in bit 4 |
| prgRomSel | output | 1 | Program memory select |
| prgRomAddr | output | $clog2(PRG_BANKS)+14 | Program memory address |
| wramCe | output | 1 | Work RAM enable, active high |
| chrSel | output | 1 | Pattern memory select |
| chrAddr | output | 17 | Pattern memory address |
| mirrorMode | output | 2 | Nametable arrangement code |
| ntPage | output | 1 | Nametable page for the current picture-unit address |

## Verification
The hardest case is a program selector that exceeds the bank count while 16 KB mode pins the last bank. In that case a wrapped selected bank and the pinned bank must be told apart in the same window pair. The default count of 8 leaves half of the 4-bit selector range out of range. Directed vectors therefore cover selectors 7 to 15 across all three program layouts, at both window edges ($BFFF/$C000 and $FFFF). A long random sweep then covers the mode words and the remaining address space.

// File: rtl/bank_xlate_pkg.sv
package bank_xlate_pkg;
  localparam int CPU_AW     = 16;
  localparam int PPU_AW     = 14;
  localparam int REG_W      = 5;
  localparam int PRG_WIN_AW = 14;
  localparam int CHR_WIN_AW = 12;
  localparam int CHR_AW     = REG_W + CHR_WIN_AW;

  typedef enum logic [1:0] {
    ARR_SINGLE_LO = 2'd0,
    ARR_SINGLE_HI = 2'd1,
    ARR_VERTICAL  = 2'd2,
    ARR_HORIZONTAL = 2'd3
  } arrange_e;

  typedef struct packed {
    logic     prgWhole;    // one 32 KB program window
    logic     swapAtLow;   // switchable 16 KB window sits at $8000
    logic     chrSplit;    // two 4 KB pattern windows
    arrange_e arrange;
  } xlateStrb_t;
endpackage

// File: rtl/bank_xlate_ctrl.sv
module bank_xlate_ctrl
  import bank_xlate_pkg::*;
(
  input  logic [REG_W-1:0] ctrlReg,
  input  logic             wramOff,
  input  logic [2:0]       cpuTop,
  input  logic             ppuHigh,
  output xlateStrb_t       strb,
  output logic             prgRomSel,
  output logic             wramCe,
  output logic             chrSel
);
  always_comb begin
    strb.prgWhole  = ~ctrlReg[3];
    strb.swapAtLow = ctrlReg[2];
    strb.chrSplit  = ctrlReg[4];
    strb.arrange   = arrange_e'(ctrlReg[1:0]);
  end

  assign prgRomSel = cpuTop[2];
  assign wramCe    = (cpuTop == 3'b011) && !wramOff;
  assign chrSel    = ~ppuHigh;
endmodule

// File: rtl/bank_xlate_dp.sv
module bank_xlate_dp
  import bank_xlate_pkg::*;
#(
  parameter int PRG_BANKS = 8,
  localparam int BANK_W = $clog2(PRG_BANKS),
  localparam int PRG_AW = BANK_W + PRG_WIN_AW
) (
  input  xlateStrb_t        strb,
  input  logic [14:0]       cpuOff,
  input  logic [12:0]       ppuOff,
  input  logic [3:0]        prgBank,
  input  logic [REG_W-1:0]  chrLoReg,
  input  logic [REG_W-1:0]  chrHiReg,
  output logic [PRG_AW-1:0] prgRomAddr,
  output logic [CHR_AW-1:0] chrAddr,
  output logic              ntPage
);
  localparam logic [31:0] BANK_CNT  = 32'(PRG_BANKS);
  localparam logic [31:0] LAST_BANK = BANK_CNT - 32'd1;

  logic [31:0]       rawBank;
  logic [BANK_W-1:0] bankIdx;
  logic              upperHalf;

  assign upperHalf = cpuOff[14];

  always_comb begin
    if (strb.prgWhole)
      rawBank = {28'd0, prgBank[3:1], upperHalf};
    else if (strb.swapAtLow)
      rawBank = upperHalf ? LAST_BANK : {28'd0, prgBank};
    else
      rawBank = upperHalf ? {28'd0, prgBank} : 32'd0;
  end

  assign bankIdx    = BANK_W'(rawBank % BANK_CNT);
  assign prgRomAddr = {bankIdx, cpuOff[13:0]};

  always_comb begin
    if (strb.chrSplit)
      chrAddr = {(ppuOff[12] ? chrHiReg : chrLoReg), ppuOff[11:0]};
    else
      chrAddr = {chrLoReg[REG_W-1:1], ppuOff};
  end

  always_comb begin
    unique case (strb.arrange)
      ARR_SINGLE_LO:  ntPage = 1'b0;
      ARR_SINGLE_HI:  ntPage = 1'b1;
      ARR_VERTICAL:   ntPage = ppuOff[10];
      ARR_HORIZONTAL: ntPage = ppuOff[11];
      default:        ntPage = 1'b0;
    endcase
  end
endmodule

// File: rtl/bank_xlate.sv
module bank_xlate
  import bank_xlate_pkg::*;
#(
  parameter int PRG_BANKS = 8,
  localparam int PRG_AW = $clog2(PRG_BANKS) + PRG_WIN_AW
) (
  input  logic [CPU_AW-1:0] cpuAddr,
  input  logic [PPU_AW-1:0] ppuAddr,
  input  logic [REG_W-1:0]  ctrlReg,
  input  logic [REG_W-1:0]  chrLoReg,
  input  logic [REG_W-1:0]  chrHiReg,
  input  logic [REG_W-1:0]  prgReg,
  output logic              prgRomSel,
  output logic [PRG_AW-1:0] prgRomAddr,
  output logic              wramCe,
  output logic              chrSel,
  output logic [CHR_AW-1:0] chrAddr,
  output logic [1:0]        mirrorMode,
  output logic              ntPage
);
  xlateStrb_t strb;

  bank_xlate_ctrl ctrl_i (
    .ctrlReg   (ctrlReg),
    .wramOff   (prgReg[4]),
    .cpuTop    (cpuAddr[15:13]),
    .ppuHigh   (ppuAddr[13]),
    .strb      (strb),
    .prgRomSel (prgRomSel),
    .wramCe    (wramCe),
    .chrSel    (chrSel)
  );

  bank_xlate_dp #(.PRG_BANKS(PRG_BANKS)) dp_i (
    .strb       (strb),
    .cpuOff     (cpuAddr[14:0]),
    .ppuOff     (ppuAddr[12:0]),
    .prgBank    (prgReg[3:0]),
    .chrLoReg   (chrLoReg),
    .chrHiReg   (chrHiReg),
    .prgRomAddr (prgRomAddr),
    .chrAddr    (chrAddr),
    .ntPage     (ntPage)
  );

  assign mirrorMode = strb.arrange;
endmodule

// File: rtl/bank_xlate_chk.sv
module bank_xlate_chk
  import bank_xlate_pkg::*;
#(
  parameter int PRG_BANKS = 8,
  localparam int BANK_W = $clog2(PRG_BANKS),
  localparam int PRG_AW = BANK_W + PRG_WIN_AW
) (
  input logic [CPU_AW-1:0] cpuAddr,
  input logic [PPU_AW-1:0] ppuAddr,
  input logic [REG_W-1:0]  ctrlReg,
  input logic [REG_W-1:0]  chrLoReg,
  input logic [REG_W-1:0]  chrHiReg,
  input logic [REG_W-1:0]  prgReg,
  input logic              prgRomSel,
  input logic [PRG_AW-1:0] prgRomAddr,
  input logic              wramCe,
  input logic              chrSel,
  input logic [CHR_AW-1:0] chrAddr,
  input logic [1:0]        mirrorMode,
  input logic              ntPage
);
  localparam logic [BANK_W-1:0] LAST_IDX = BANK_W'(PRG_BANKS - 1);

  always_comb begin
    p_arrange_code_r1: assert (mirrorMode == ctrlReg[1:0]);
    if (!ctrlReg[3])
      p_whole_offset_r2: assert (prgRomAddr[13:0] == cpuAddr[13:0]);
    if (ctrlReg[3] && ctrlReg[2] && cpuAddr[14])
      p_pinned_last_r3: assert (prgRomAddr[PRG_AW-1:PRG_WIN_AW] == LAST_IDX);
    if (ctrlReg[3] && !ctrlReg[2] && !cpuAddr[14])
      p_pinned_first_r4: assert (prgRomAddr[PRG_AW-1:PRG_WIN_AW] == '0);
    if (prgRomSel)
      p_rom_not_wram_r6: assert (!wramCe);
    if (!ctrlReg[4])
      p_chr_whole_r7: assert (chrAddr[12:0] == ppuAddr[12:0]
                              && chrAddr[CHR_AW-1:13] == chrLoReg[REG_W-1:1]);
    if (ctrlReg[4])
      p_chr_split_r8: assert (chrAddr[11:0] == ppuAddr[11:0]
                              && chrAddr[CHR_AW-1:12] == (ppuAddr[12] ? chrHiReg : chrLoReg));
    if (chrSel)
      p_chr_sel_r9: assert (!ppuAddr[13]);
    if (wramCe)
      p_wram_gate_r10: assert (!prgReg[4] && cpuAddr[15:13] == 3'b011);
    if (ctrlReg[1:0] == 2'd2)
      p_page_vert_r11: assert (ntPage == ppuAddr[10]);
  end
endmodule

bind bank_xlate bank_xlate_chk #(.PRG_BANKS(PRG_BANKS)) chk_i (.*);

// File: tb/bank_xlate_tb_top.sv
module bank_xlate_tb_top;
  localparam int NB = 8;
  localparam int PAW = $clog2(NB) + 14;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] cpuAddr = '0;
  logic [13:0] ppuAddr = '0;
  logic [4:0]  ctrlReg = '0, chrLoReg = '0, chrHiReg = '0, prgReg = '0;
  logic        prgRomSel, wramCe, chrSel, ntPage;
  logic [PAW-1:0] prgRomAddr;
  logic [16:0] chrAddr;
  logic [1:0]  mirrorMode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bank_xlate #(.PRG_BANKS(NB)) dut_i (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cpu=%h ppu=%h ctrl=%b prg=%h lo=%h hi=%h)",
               req, act, exp, cpuAddr, ppuAddr, ctrlReg, prgReg, chrLoReg, chrHiReg);
    end
  endtask

  // behavioural reference, compared on each falling edge
  task automatic compare();
    int c = cpuAddr, p = ppuAddr, bank, sel, tag;
    int mode = ctrlReg[1:0];
    string prgReq;
    sel = prgReg[3:0];
    if (ctrlReg[3] == 1'b0) begin
      bank = ((sel / 2) * 2 + ((c >= 'hC000 || (c < 'h8000 && (c % 'h8000) >= 'h4000)) ? 1 : 0)) % NB;
      prgReq = "R2";
    end else if (ctrlReg[2]) begin
      bank = ((c % 'h8000) < 'h4000) ? sel % NB : NB - 1;
      prgReq = "R3";
    end else begin
      bank = ((c % 'h8000) < 'h4000) ? 0 : sel % NB;
      prgReq = "R4";
    end
    chk({prgReq, "/R5 prgRomAddr"}, int'(prgRomAddr), bank * 16384 + (c % 16384));
    chk("R6 prgRomSel", int'(prgRomSel), (c >= 'h8000) ? 1 : 0);
    chk("R10 wramCe", int'(wramCe), (c >= 'h6000 && c < 'h8000 && prgReg[4] == 0) ? 1 : 0);
    if (ctrlReg[4] == 1'b0)
      chk("R7 chrAddr", int'(chrAddr), (chrLoReg / 2) * 8192 + (p % 8192));
    else begin
      tag = ((p % 8192) < 4096) ? chrLoReg : chrHiReg;
      chk("R8 chrAddr", int'(chrAddr), tag * 4096 + (p % 4096));
    end
    chk("R9 chrSel", int'(chrSel), (p < 'h2000) ? 1 : 0);
    chk("R1 mirrorMode", int'(mirrorMode), mode);
    chk("R11 ntPage", int'(ntPage),
        (mode == 0) ? 0 : (mode == 1) ? 1 : (mode == 2) ? (p / 1024) % 2 : (p / 2048) % 2);
  endtask

  task automatic apply(int c, int p, int ct, int lo, int hi, int pr);
    @(posedge clk);
    cpuAddr = 16'(c); ppuAddr = 14'(p); ctrlReg = 5'(ct);
    chrLoReg = 5'(lo); chrHiReg = 5'(hi); prgReg = 5'(pr);
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // reset-like all-zero inputs
    @(negedge clk); compare();
    // R2 / R3 / R4 / R5: window edges with selectors beyond the bank count
    for (int s = 7; s < 16; s++)
      for (int m = 0; m < 3; m++) begin
        int ct = (m == 0) ? 5'b00000 : (m == 1) ? 5'b01100 : 5'b01000;
        apply('h8000, 0, ct, 0, 0, s);
        apply('hBFFF, 0, ct, 0, 0, s);
        apply('hC000, 0, ct, 0, 0, s);
        apply('hFFFF, 0, ct, 0, 0, s);
      end
    // R10: work RAM window edges with bit 4 both ways
    apply('h5FFF, 0, 0, 0, 0, 'h00);
    apply('h6000, 0, 0, 0, 0, 'h00);
    apply('h7FFF, 0, 0, 0, 0, 'h00);
    apply('h7FFF, 0, 0, 0, 0, 'h10);
    apply('h8000, 0, 'b01100, 0, 0, 'h13); // R10: bit 4 leaves the program address alone
    // R7 / R8 / R9: pattern windows, R7 with chrHi changing
    apply(0, 'h0FFF, 'b00000, 'h1F, 'h00, 0);
    apply(0, 'h1000, 'b00000, 'h1F, 'h15, 0);
    apply(0, 'h0FFF, 'b10000, 'h1F, 'h15, 0);
    apply(0, 'h1000, 'b10000, 'h1F, 'h15, 0);
    apply(0, 'h1FFF, 'b10000, 'h03, 'h1E, 0);
    apply(0, 'h2000, 'b10000, 'h03, 'h1E, 0);
    // R1 / R11: every arrangement at page-boundary addresses
    for (int m = 0; m < 4; m++) begin
      apply(0, 'h2400, m, 0, 0, 0);
      apply(0, 'h2800, m, 0, 0, 0);
      apply(0, 'h2C00, m, 0, 0, 0);
    end
    // broad random sweep
    for (int i = 0; i < 3000; i++)
      apply($urandom_range(0, 'hFFFF), $urandom_range(0, 'h3FFF), $urandom_range(0, 31),
            $urandom_range(0, 31), $urandom_range(0, 31), $urandom_range(0, 31));
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule